// File: doc/BRIEF.md
# Serial EEPROM configuration auto-loader

This block runs once after every system reset. It fetches a small configuration image, one byte at a time, from an external byte-addressed EEPROM. It fetches through a request/acknowledge byte-read port that faces a separate EEPROM access engine. The serial wire protocol sits entirely behind that port.

The first byte fetched is a signature. When the signature is 0xA5, the block keeps reading the next ten bytes. It places them into a 48-bit station address, a 16-bit subsystem ID and a 16-bit subsystem vendor ID. When the signature holds any other value, the EEPROM is treated as absent or blank. The block then stops at once and leaves the hard default values on its outputs.

A done flag marks the end of the sequence on either path. A loaded flag is raised only on the valid path.

Top module: `cfg_autoload`

## Requirements
- R1: In the first cycle after the first clock edge that follows reset release, `rd_req_o` is high and `rd_addr_o` is 0x00.
- R2: The image is accepted only when byte 0x00 reads exactly 0xA5.
- R3: On the valid path, bytes 0x01 through 0x06 fill `station_addr_o` lowest byte first: byte 0x01 goes to bits [7:0] and byte 0x06 goes to bits [47:40].
- R4: On the valid path, byte 0x07 is the low byte and 0x08 the high byte of `subsys_id_o`. Byte 0x09 is the low byte and 0x0A the high byte of `subsys_vid_o`.
- R5: `loaded_o` stays low until the acknowledge for address 0x0A. It rises together with `done_o`, one cycle after that acknowledge.
- R6: With a bad signature, exactly one byte is read. `done_o` rises one cycle after that acknowledge. `loaded_o` stays 0. The outputs keep their defaults: ID 0x9420, vendor ID 0x1055, station address 0xFFFF_FFFF_FFFF.
- R7: Addresses are requested in strictly ascending order starting at 0x00. No address above 0x0A is ever requested.
- R8: A request holds `rd_req_o` and `rd_addr_o` steady until `rd_ack_i`. Any acknowledge while `rd_req_o` is low is ignored.
- R9: Once `done_o` is high, it stays high until the next reset. No further request is issued, and `loaded_o` and all value outputs stay fixed.
- R10: While reset is asserted, the outputs show the defaults, with `done_o`, `loaded_o` and `rd_req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | 8 | EEPROM byte address of the request |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 8 | Byte returned with the acknowledge |
| station_addr_o | output | 48 | Station address |
| subsys_id_o | output | 16 | Subsystem ID |
| subsys_vid_o | output | 16 | Subsystem vendor ID |
| loaded_o | output | 1 | Image accepted and fully loaded |
| done_o | output | 1 | Sequence finished (either path) |

## Verification
The bench tries signatures one bit away from 0xA5 and other near-miss values. A loose compare there would load garbage where the defaults must stay. Acknowledges arrive after random delays, and stray acknowledges are sent both after completion and while no request is pending. A design that latches data without a pending request would corrupt the loaded values, and one that reads past 0x0A would show up as a wrong read count. Each byte's landing position is checked against random images, which catches swapped byte order or mixed-up identifier order. The loaded flag is watched every cycle, so raising it early would be seen.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [1:0] {ST_START, ST_READ, ST_END} seq_state_e;
endpackage

// File: rtl/al_seq_ctrl.sv
module al_seq_ctrl
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 8,
  parameter int unsigned         PAYLOAD  = 10,
  parameter logic [BYTE_W-1:0]   SIG_BYTE = 8'hA5,
  localparam int unsigned        LANE_W   = (PAYLOAD > 1) ? $clog2(PAYLOAD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [LANE_W-1:0] wr_lane_o,
  output logic              loaded_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PAYLOAD);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              loaded_q;
  logic              xfer;

  assign rd_req_o  = (state_q == ST_READ);
  assign rd_addr_o = addr_q;
  assign xfer      = rd_req_o && rd_ack_i;
  assign done_o    = (state_q == ST_END);
  assign loaded_o  = loaded_q;
  assign wr_en_o   = xfer && (addr_q != '0);
  assign wr_lane_o = LANE_W'(addr_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_START;
      addr_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_START: state_q <= ST_READ;
        ST_READ: if (xfer) begin
          if (addr_q == '0 && rd_data_i != SIG_BYTE) begin
            state_q <= ST_END;  // blank or absent part
          end else if (addr_q == LAST_ADDR) begin
            state_q  <= ST_END;
            loaded_q <= 1'b1;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        default: state_q <= ST_END;
      endcase
    end
  end

  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  a_r7_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o <= LAST_ADDR);
  a_r7_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> done_o || (rd_addr_o == $past(rd_addr_o) + 1'b1));
  a_r5_loaded_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |-> done_o);
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(loaded_o) && !rd_req_o);
endmodule

// File: rtl/al_image_regs.sv
module al_image_regs
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned            PAYLOAD = 10,
  parameter logic [PAYLOAD*BYTE_W-1:0] DEF_IMG = '1,
  localparam int unsigned           LANE_W  = (PAYLOAD > 1) ? $clog2(PAYLOAD) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [LANE_W-1:0]           wr_lane_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  output logic [PAYLOAD*BYTE_W-1:0]   image_o
);
  for (genvar k = 0; k < PAYLOAD; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     image_o[k*BYTE_W +: BYTE_W] <= DEF_IMG[k*BYTE_W +: BYTE_W];
      else if (wr_en_i && wr_lane_i == LANE_W'(k))     image_o[k*BYTE_W +: BYTE_W] <= wr_data_i;
    end
  end

  a_r3_lane_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> 32'(wr_lane_i) < PAYLOAD);
  a_r9_image_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(image_o));
endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       MAC_BYTES = 6,
  parameter int unsigned       ID_BYTES  = 2,
  parameter logic [BYTE_W-1:0] SIG_BYTE  = 8'hA5,
  parameter logic [MAC_BYTES*BYTE_W-1:0] DEF_MAC  = 48'hFFFF_FFFF_FFFF,
  parameter logic [ID_BYTES*BYTE_W-1:0]  DEF_SID  = 16'h9420,
  parameter logic [ID_BYTES*BYTE_W-1:0]  DEF_SVID = 16'h1055
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  output logic                          rd_req_o,
  output logic [ADDR_W-1:0]             rd_addr_o,
  input  logic                          rd_ack_i,
  input  logic [BYTE_W-1:0]             rd_data_i,
  output logic [MAC_BYTES*BYTE_W-1:0]   station_addr_o,
  output logic [ID_BYTES*BYTE_W-1:0]    subsys_id_o,
  output logic [ID_BYTES*BYTE_W-1:0]    subsys_vid_o,
  output logic                          loaded_o,
  output logic                          done_o
);
  localparam int unsigned PAYLOAD = MAC_BYTES + 2 * ID_BYTES;
  localparam int unsigned LANE_W  = (PAYLOAD > 1) ? $clog2(PAYLOAD) : 1;
  localparam int unsigned MAC_W   = MAC_BYTES * BYTE_W;
  localparam int unsigned ID_W    = ID_BYTES * BYTE_W;
  localparam logic [PAYLOAD*BYTE_W-1:0] DEF_IMG = {DEF_SVID, DEF_SID, DEF_MAC};

  logic                      wr_en;
  logic [LANE_W-1:0]         wr_lane;
  logic [PAYLOAD*BYTE_W-1:0] image;

  al_seq_ctrl #(.ADDR_W(ADDR_W), .PAYLOAD(PAYLOAD), .SIG_BYTE(SIG_BYTE)) i_ctrl (
    .clk_i, .rst_ni, .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
    .wr_en_o(wr_en), .wr_lane_o(wr_lane), .loaded_o, .done_o
  );

  al_image_regs #(.PAYLOAD(PAYLOAD), .DEF_IMG(DEF_IMG)) i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_lane_i(wr_lane),
    .wr_data_i(rd_data_i), .image_o(image)
  );

  assign station_addr_o = image[0 +: MAC_W];
  assign subsys_id_o    = image[MAC_W +: ID_W];
  assign subsys_vid_o   = image[MAC_W+ID_W +: ID_W];

  a_r6_defaults_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !loaded_o |-> image == DEF_IMG);
  a_r9_values_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(station_addr_o) && $stable(subsys_id_o) && $stable(subsys_vid_o));
endmodule

// File: tb/test_cfg_autoload.sv
module test_cfg_autoload;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_req_o, rd_ack_i, loaded_o, done_o;
  logic [7:0]  rd_addr_o, rd_data_i;
  logic [47:0] station_addr_o;
  logic [15:0] subsys_id_o, subsys_vid_o;

  always #2 clk_i = ~clk_i;

  cfg_autoload i_cfg_autoload (.*);

  logic [7:0] mem [256];
  int n_chk = 0, n_bad = 0;
  int rd_cnt, max_d, dly;
  logic seq_err, spur_en;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_mac();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = mem[i+1];
    return v;
  endfunction

  // EEPROM engine model
  initial begin
    rd_ack_i = 1'b0; rd_data_i = '0; dly = 0;
    forever begin
      @(negedge clk_i);
      if (rd_ack_i) begin
        rd_ack_i = 1'b0;
        dly = $urandom_range(max_d, 0);
      end else if (rd_req_o) begin
        if (dly == 0) begin
          rd_ack_i = 1'b1;
          rd_data_i = mem[rd_addr_o];
          if (32'(rd_addr_o) != rd_cnt) seq_err = 1'b1;
          rd_cnt++;
        end else begin
          dly--;
          rd_data_i = 8'($urandom);
        end
      end else if (spur_en) begin
        rd_ack_i = 1'b1;               // stray ack, no request pending
        rd_data_i = 8'($urandom);
      end
    end
  end

  task automatic run_case(input logic [7:0] sig, input int dmax);
    int cyc;
    logic ok;
    logic [47:0] m; logic [15:0] s, v;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[0] = sig; max_d = dmax;
    rd_cnt = 0; seq_err = 1'b0; spur_en = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 req", 64'(rd_req_o), 0);
    chk("R10 flags", {62'd0, done_o, loaded_o}, 0);
    chk("R10 defaults", {station_addr_o, subsys_id_o}, {48'hFFFF_FFFF_FFFF, 16'h9420});
    chk("R10 vid", 64'(subsys_vid_o), 64'h1055);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 first request", {55'd0, rd_req_o, rd_addr_o}, {55'd0, 1'b1, 8'h00});
    cyc = 0; ok = 1'b1;
    while (!done_o && cyc < 500) begin
      @(posedge clk_i); #1; cyc++;
      if (loaded_o && !done_o) ok = 1'b0;
    end
    if (cyc >= 500) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=%0d expected<500", cyc);
    end
    chk("R5 loaded never before done", 64'(ok), 1);
    chk("R7 ascending addresses", 64'(seq_err), 0);
    if (sig == 8'hA5) begin
      chk("R2/R5 loaded on valid", {62'd0, done_o, loaded_o}, 3);
      chk("R7 read count valid", 64'(rd_cnt), 11);
      chk("R3 station address", 64'(station_addr_o), 64'(exp_mac()));
      chk("R4 ids", {subsys_vid_o, subsys_id_o}, {mem[10], mem[9], mem[8], mem[7]});
    end else begin
      chk("R6 flags on bad sig", {62'd0, done_o, loaded_o}, 2);
      chk("R6 read count bad sig", 64'(rd_cnt), 1);
      chk("R6 defaults kept", {station_addr_o, subsys_id_o}, {48'hFFFF_FFFF_FFFF, 16'h9420});
      chk("R6 vid default", 64'(subsys_vid_o), 64'h1055);
    end
    m = station_addr_o; s = subsys_id_o; v = subsys_vid_o;
    spur_en = 1'b1;
    repeat (6) @(posedge clk_i);
    #1; spur_en = 1'b0;
    chk("R9 no request, done held", {62'd0, rd_req_o, done_o}, 1);
    chk("R8 stray ack ignored", {station_addr_o, s}, {m, s});
    chk("R8 stray ack ids", {s, v, 32'(rd_cnt)}, {subsys_id_o, subsys_vid_o, (sig == 8'hA5) ? 32'd11 : 32'd1});
  endtask

  initial begin
    void'($urandom(32'd4711));
    max_d = 0; rd_cnt = 0; seq_err = 1'b0; spur_en = 1'b0;
    run_case(8'hA5, 0);
    run_case(8'hA5, 3);
    run_case(8'h00, 2);
    run_case(8'hA4, 1);   // one bit off
    run_case(8'hA7, 0);   // one bit off
    run_case(8'h25, 0);   // one bit off, top
    run_case(8'hFF, 3);   // blank part
    run_case(8'hA5, 7);
    for (int t = 0; t < 6; t++) begin
      logic [7:0] sg;
      sg = ($urandom_range(1, 0) == 1) ? 8'hA5 : 8'($urandom);
      run_case(sg, $urandom_range(4, 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule